// File: doc/BRIEF.md
# Pseudo-Ternary Line Codec

This block converts between a binary bit stream and a three-level line symbol stream using alternate mark inversion of zeros. On the send side a binary 0 becomes a mark whose polarity alternates from one mark to the next, while a binary 1 leaves the line quiet. On the receive side each symbol is turned back into a bit. A mark that repeats the polarity of the mark before it is flagged as a bipolar violation. A long unbroken run of received zeros pulls an active-low reset indication low.

Each line symbol is a two-bit pair, positive and negative, and there is one symbol per bit cell. The surrounding logic supplies one-clock strobes at the cell rate, nominally 192 kbit/s, separately for the send and receive directions. Symbols use 100% pulse width, so every output stays constant for the whole cell. A deliberate violation can be injected on the send side, for example to mark frame boundaries. The analog front end, clock recovery and frame alignment sit outside this block.

Top module: `ptern_codec`

## Requirements
- R1: On a send strobe, `tx_bit`=1 produces a space (`tx_pos`=0, `tx_neg`=0) and `tx_bit`=0 produces a mark (exactly one of `tx_pos`, `tx_neg` high).
- R2: Sent marks alternate in polarity. After reset the last mark is taken as negative, so the first mark is positive (`tx_pos`=1).
- R3: With `tx_force_viol`=1 and `tx_bit`=0, the mark repeats the polarity of the previous mark, and later marks alternate from it. With `tx_bit`=1, `tx_force_viol` has no effect and a space is sent.
- R4: Every output changes only in the clock cycle after a strobe of its own direction. Between strobes it holds its value for the whole cell.
- R5: The symbol encoding is {pos,neg}: 10 is a positive mark, 01 is a negative mark, 00 is a space, and 11 is illegal.
- R6: On a receive strobe, a mark decodes to `rx_bit`=0 and a space decodes to `rx_bit`=1.
- R7: `rx_viol` is set for a received mark with the same polarity as the previous received mark. After reset the previous received mark is taken as negative.
- R8: A received 11 symbol decodes as `rx_bit`=1 with `rx_illegal`=1 and `rx_viol`=0. It leaves the receive polarity tracker unchanged.
- R9: `rst_out_n` goes low in the cycle after the receive strobe that carries the 128th consecutive mark (parameter `RUN_LIMIT`). It stays low while further marks arrive.
- R10: Any received space or illegal symbol clears the run count. `rst_out_n` returns high with the same update.
- R11: After reset, `tx_pos`=`tx_neg`=0, `rx_bit`=1, `rx_viol`=`rx_illegal`=0 and `rst_out_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Send cell strobe, one clock per bit cell |
| tx_bit | input | 1 | Binary bit to send |
| tx_force_viol | input | 1 | Send this mark with the previous mark's polarity |
| tx_pos | output | 1 | Positive pulse of the sent symbol |
| tx_neg | output | 1 | Negative pulse of the sent symbol |
| rx_en | input | 1 | Receive cell strobe, one clock per bit cell |
| rx_pos | input | 1 | Positive pulse of the received symbol |
| rx_neg | input | 1 | Negative pulse of the received symbol |
| rx_bit | output | 1 | Decoded bit |
| rx_viol | output | 1 | Bipolar violation on the last received cell |
| rx_illegal | output | 1 | Last received symbol had both pulses high |
| rst_out_n | output | 1 | Active-low reset indication after a long zero run |

## Verification
The assertions assume that `rx_pos` and `rx_neg` are stable and valid at each `rx_en` strobe. They also assume that strobes are single-cycle pulses and that symbol timing is free-running. The bench drives every input on the falling clock edge and raises each strobe for exactly one cycle. It leaves idle cycles between cells, so the hold behaviour is observed while inputs change with no strobe present. The bench applies illegal 11 symbols on purpose, and the checks tolerate them because that code is part of the defined decode behaviour.

// File: rtl/ptern_pkg.sv
package ptern_pkg;

  typedef struct packed {
    logic pos;
    logic neg;
  } sym_t;

  localparam sym_t SYM_SPACE = '{pos: 1'b0, neg: 1'b0};

  // Polarity of the next mark: alternate unless a violation is forced.
  function automatic logic next_pol(input logic last_pos, input logic force_same);
    return force_same ? last_pos : ~last_pos;
  endfunction

  function automatic sym_t mark_sym(input logic positive);
    sym_t s;
    s.pos = positive;
    s.neg = ~positive;
    return s;
  endfunction

  function automatic logic is_mark(input sym_t s);
    return s.pos ^ s.neg;
  endfunction

  function automatic logic is_illegal(input sym_t s);
    return s.pos & s.neg;
  endfunction

  // Saturating run increment.
  function automatic int unsigned run_next(input int unsigned cur, input int unsigned limit);
    return (cur >= limit) ? limit : cur + 1;
  endfunction

endpackage

// File: rtl/ptern_encoder.sv
module ptern_encoder
  import ptern_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cell_en,
  input  logic data_bit,
  input  logic force_viol,
  output sym_t sym_q,
  output logic last_pos_q,
  output logic mark_fire
);

  logic pol_now;

  assign mark_fire = cell_en & ~data_bit;
  assign pol_now   = next_pol(last_pos_q, force_viol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q      <= SYM_SPACE;
      last_pos_q <= 1'b0;
    end else if (cell_en) begin
      if (data_bit) begin
        sym_q <= SYM_SPACE;
      end else begin
        sym_q      <= mark_sym(pol_now);
        last_pos_q <= pol_now;
      end
    end
  end

endmodule

// File: rtl/ptern_decoder.sv
module ptern_decoder
  import ptern_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cell_en,
  input  sym_t sym_in,
  output logic bit_q,
  output logic viol_q,
  output logic illegal_q,
  output logic mark_now,
  output logic last_pos_q
);

  logic bad_now;
  logic repeat_pol;

  assign mark_now   = cell_en & is_mark(sym_in);
  assign bad_now    = is_illegal(sym_in);
  assign repeat_pol = (sym_in.pos == last_pos_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q      <= 1'b1;
      viol_q     <= 1'b0;
      illegal_q  <= 1'b0;
      last_pos_q <= 1'b0;
    end else if (cell_en) begin
      bit_q     <= ~is_mark(sym_in);
      illegal_q <= bad_now;
      viol_q    <= is_mark(sym_in) & repeat_pol;
      if (is_mark(sym_in)) last_pos_q <= sym_in.pos;
    end
  end

endmodule

// File: rtl/ptern_run_counter.sv
module ptern_run_counter
  import ptern_pkg::*;
#(
  parameter int unsigned RUN_LIMIT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cell_en,
  input  logic mark_in,
  output logic full
);

  localparam int unsigned CNT_W = $clog2(RUN_LIMIT + 1);

  logic [CNT_W-1:0] run_q;
  int unsigned      run_inc;

  assign run_inc = run_next(int'(run_q), RUN_LIMIT);
  assign full    = (int'(run_q) >= RUN_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (cell_en) begin
      run_q <= mark_in ? CNT_W'(run_inc) : '0;
    end
  end

endmodule

// File: rtl/ptern_codec.sv
module ptern_codec
  import ptern_pkg::*;
#(
  parameter int unsigned RUN_LIMIT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic tx_bit,
  input  logic tx_force_viol,
  output logic tx_pos,
  output logic tx_neg,
  input  logic rx_en,
  input  logic rx_pos,
  input  logic rx_neg,
  output logic rx_bit,
  output logic rx_viol,
  output logic rx_illegal,
  output logic rst_out_n
);

  sym_t tx_sym;
  sym_t rx_sym;
  logic enc_last_pos;
  logic enc_mark_fire;
  logic dec_mark_now;
  logic dec_last_pos;
  logic run_full;

  assign rx_sym.pos = rx_pos;
  assign rx_sym.neg = rx_neg;

  ptern_encoder u_enc (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_en    (tx_en),
    .data_bit   (tx_bit),
    .force_viol (tx_force_viol),
    .sym_q      (tx_sym),
    .last_pos_q (enc_last_pos),
    .mark_fire  (enc_mark_fire)
  );

  ptern_decoder u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_en    (rx_en),
    .sym_in     (rx_sym),
    .bit_q      (rx_bit),
    .viol_q     (rx_viol),
    .illegal_q  (rx_illegal),
    .mark_now   (dec_mark_now),
    .last_pos_q (dec_last_pos)
  );

  ptern_run_counter #(.RUN_LIMIT(RUN_LIMIT)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .cell_en (rx_en),
    .mark_in (dec_mark_now),
    .full    (run_full)
  );

  assign tx_pos    = tx_sym.pos;
  assign tx_neg    = tx_sym.neg;
  assign rst_out_n = ~run_full;

endmodule

// File: rtl/ptern_codec_chk.sv
module ptern_codec_chk #(
  parameter int unsigned RUN_LIMIT = 128
) (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic tx_bit,
  input logic tx_force_viol,
  input logic tx_pos,
  input logic tx_neg,
  input logic rx_en,
  input logic rx_pos,
  input logic rx_neg,
  input logic rx_bit,
  input logic rx_viol,
  input logic rx_illegal,
  input logic rst_out_n,
  input logic enc_last_pos,
  input logic dec_last_pos
);

  int unsigned chk_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_run <= 0;
    else if (rx_en) chk_run <= (rx_pos ^ rx_neg) ? chk_run + 1 : 0;
  end

  // R1
  a_r1_space: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en && tx_bit |=> !tx_pos && !tx_neg);
  // R5
  a_r5_no_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_pos && tx_neg));
  // R2
  a_r2_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en && !tx_bit && !tx_force_viol |=> tx_pos == !$past(enc_last_pos));
  // R3
  a_r3_forced: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en && !tx_bit && tx_force_viol |=> tx_pos == $past(enc_last_pos));
  // R4
  a_r4_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> $stable({tx_pos, tx_neg}));
  a_r4_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> $stable({rx_bit, rx_viol, rx_illegal}));
  // R8
  a_r8_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && rx_pos && rx_neg |=> rx_bit && rx_illegal && !rx_viol && $stable(dec_last_pos));
  // R7
  a_r7_viol_is_mark: assert property (@(posedge clk) disable iff (!rst_n)
    rx_viol |-> !rx_bit && !rx_illegal);
  // R6
  a_r6_mark_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && (rx_pos ^ rx_neg) |=> !rx_bit);
  // R9
  a_r9_run_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_run >= RUN_LIMIT) == !rst_out_n);
  // R10
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && !(rx_pos ^ rx_neg) |=> rst_out_n);

endmodule

bind ptern_codec ptern_codec_chk #(.RUN_LIMIT(RUN_LIMIT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_en         (tx_en),
  .tx_bit        (tx_bit),
  .tx_force_viol (tx_force_viol),
  .tx_pos        (tx_pos),
  .tx_neg        (tx_neg),
  .rx_en         (rx_en),
  .rx_pos        (rx_pos),
  .rx_neg        (rx_neg),
  .rx_bit        (rx_bit),
  .rx_viol       (rx_viol),
  .rx_illegal    (rx_illegal),
  .rst_out_n     (rst_out_n),
  .enc_last_pos  (enc_last_pos),
  .dec_last_pos  (dec_last_pos)
);

// File: tb/ptern_codec_bench.sv
`timescale 1ns/1ps
module ptern_codec_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, tx_bit = 1'b1, tx_force_viol = 1'b0;
  logic rx_en = 1'b0, rx_pos = 1'b0, rx_neg = 1'b0;
  logic tx_pos, tx_neg, rx_bit, rx_viol, rx_illegal, rst_out_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ptern_codec u_ptern_codec (
    .clk(clk), .rst_n(rst_n),
    .tx_en(tx_en), .tx_bit(tx_bit), .tx_force_viol(tx_force_viol),
    .tx_pos(tx_pos), .tx_neg(tx_neg),
    .rx_en(rx_en), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .rx_bit(rx_bit), .rx_viol(rx_viol), .rx_illegal(rx_illegal),
    .rst_out_n(rst_out_n)
  );

  // {tx_bit, force, exp_pos, exp_neg}
  localparam logic [3:0] TXV [8] = '{
    4'b0010, 4'b0001, 4'b1000, 4'b0010,
    4'b1100, 4'b0110, 4'b0001, 4'b0010
  };
  // {rx_pos, rx_neg, exp_bit, exp_viol, exp_illegal}
  localparam logic [4:0] RXV [8] = '{
    5'b10000, 5'b01000, 5'b00100, 5'b01010,
    5'b10000, 5'b11101, 5'b10010, 5'b01000
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tx_cell(input logic b, input logic f);
    @(negedge clk);
    tx_en = 1'b1; tx_bit = b; tx_force_viol = f;
    @(negedge clk);
    tx_en = 1'b0;
  endtask

  task automatic rx_cell(input logic p, input logic n);
    @(negedge clk);
    rx_en = 1'b1; rx_pos = p; rx_neg = n;
    @(negedge clk);
    rx_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    do_reset();
    // R11 reset state
    check("R11 reset outputs", {2'b0, tx_pos, tx_neg, rx_bit, rx_viol, rx_illegal, rst_out_n},
          8'b00_0_0_1_0_0_1);

    // Send table: R1 R2 R3 R5
    for (int i = 0; i < 8; i++) begin
      tx_cell(TXV[i][3], TXV[i][2]);
      check($sformatf("R1/R2/R3/R5 tx vector %0d", i), {6'b0, tx_pos, tx_neg},
            {6'b0, TXV[i][1:0]});
    end

    // R4 hold: change inputs with no strobe, output must stay positive mark
    tx_bit = 1'b1; tx_force_viol = 1'b1;
    repeat (4) @(negedge clk);
    check("R4 tx hold", {6'b0, tx_pos, tx_neg}, 8'b10);

    // Receive table: R5 R6 R7 R8
    for (int i = 0; i < 8; i++) begin
      rx_cell(RXV[i][4], RXV[i][3]);
      check($sformatf("R6/R7/R8 rx vector %0d", i), {5'b0, rx_bit, rx_viol, rx_illegal},
            {5'b0, RXV[i][2:0]});
    end
    rx_pos = 1'b1; rx_neg = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 rx hold", {5'b0, rx_bit, rx_viol, rx_illegal}, 8'b000);

    // R9 run of marks; last received mark was negative
    rx_cell(1'b0, 1'b0);
    for (int k = 0; k < 127; k++) rx_cell(k % 2 == 0, k % 2 != 0);
    check("R9 127 marks no reset", {7'b0, rst_out_n}, 8'd1);
    rx_cell(1'b0, 1'b1);
    check("R9 128th mark asserts", {7'b0, rst_out_n}, 8'd0);
    rx_cell(1'b1, 1'b0);
    check("R9 stays low", {7'b0, rst_out_n}, 8'd0);
    rx_cell(1'b0, 1'b0);
    check("R10 space releases", {6'b0, rst_out_n, rx_bit}, 8'b11);

    // R10 illegal symbol also releases
    for (int k = 0; k < 128; k++) rx_cell(k % 2 != 0, k % 2 == 0);
    check("R9 second run asserts", {7'b0, rst_out_n}, 8'd0);
    rx_cell(1'b1, 1'b1);
    check("R10 illegal releases", {6'b0, rst_out_n, rx_illegal}, 8'b11);

    // R2/R11 after a mid-stream reset first mark is positive again
    tx_cell(1'b0, 1'b0);
    do_reset();
    check("R11 second reset", {5'b0, tx_pos, tx_neg, rst_out_n}, 8'b001);
    tx_cell(1'b0, 1'b0);
    check("R2 first mark positive", {6'b0, tx_pos, tx_neg}, 8'b10);
    // R7 first received negative mark after reset is a violation
    rx_cell(1'b0, 1'b1);
    check("R7 first negative mark", {6'b0, rx_bit, rx_viol}, 8'b01);
    // R3 forced violation on first mark after this positive one
    tx_cell(1'b0, 1'b1);
    check("R3 forced same polarity", {6'b0, tx_pos, tx_neg}, 8'b10);

    finish_run();
  end

endmodule